// File: doc/BRIEF.md
# Register-Fed CRC-16 Calculator

This block computes a 16-bit cyclic redundancy check over bytes that software supplies one register write at a time. Software first writes the clear bit in the control register. This returns the checksum to its starting value and zeroes a count of accepted inputs. Software then writes each data unit to the input register. Every such write folds the low byte of the unit into the checksum and adds one to the count. Software reads the count from the control register and the checksum from the result register.

Each byte is folded in a single clock edge, so the new value can be read at the very next bus access. The polynomial is x^16 + x^12 + x^5 + 1. Bytes are shifted in most-significant bit first, and the start value is 0x47C3. With that start value, the fixed four-byte self-test sequence gives 0x51DF. Software can run this sequence at start-up to prove the engine works.

Top module: `bus_crc16`

## Requirements
- R1: After rst_n is released, the control register (address 0) reads 0x0000 and the result register (address 2) reads 0x47C3.
- R2: A write to address 0 with bit 15 set sets the checksum back to 0x47C3 and the count back to 0, whatever the other data bits are.
- R3: A write to address 0 with bit 15 clear, or any write to address 2 or 3, changes neither the count nor the checksum.
- R4: A write to address 1 folds bits 7:0 of the data into the checksum. The polynomial is 0x1021 and the byte is shifted in MSB first. Bits 15:8 of the data have no effect on the checksum.
- R5: Each write to address 1 adds one to the count, which reads in bits 11:0 of address 0.
- R6: The count stops at 0xFFF and does not wrap when more inputs arrive.
- R7: After a clear and the inputs 0xCC, 0xF5, 0xF1, 0xA7, the control register reads 0x0004 and the result register reads 0x51DF.
- R8: Bits 15:12 of the control register always read 0. This means the clear bit never reads back as 1.
- R9: The checksum and count updated by a write can be read in the cycle that follows that write.
- R10: Reads of address 1 and address 3 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_addr | input | 2 | Register select: 0 control, 1 input, 2 result, 3 unused |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the register selected by bus_addr (combinational) |

## Verification
The checker watches the state on every cycle. It confirms that a clear leaves the start value and a zero count, and that nothing moves without a clear or a feed. It also confirms that the count steps by exactly one until it reaches 0xFFF and then holds there, and that the top bits of the control register stay zero. Only the bench's scenarios show that the checksum values are correct. The bench compares them with an independent bitwise division for the self-test bytes, for a long pseudo-random stream and for inputs whose high bits are set. It also shows the saturation point after 4095 feeds and the next-cycle readback.

// File: rtl/bus_crc16_pkg.sv
package bus_crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int FOLD_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DIN  = 2'd1,
    SEL_DOUT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Fold one byte into the running checksum, MSB first.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] cur,
                                                input logic [FOLD_W-1:0] din,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = cur ^ {din, {(CRC_W-FOLD_W){1'b0}}};
    for (int i = 0; i < FOLD_W; i++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/bus_crc16_decode.sv
module bus_crc16_decode
  import bus_crc16_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CLEAR_BIT = 15
) (
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              do_clear,
  output logic              do_feed,
  output logic [FOLD_W-1:0] feed_byte
);
  always_comb begin
    do_clear  = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL) && bus_wdata[CLEAR_BIT];
    do_feed   = bus_wr && (reg_sel_e'(bus_addr) == SEL_DIN);
    feed_byte = bus_wdata[FOLD_W-1:0];
  end
endmodule

// File: rtl/bus_crc16_accum.sv
module bus_crc16_accum
  import bus_crc16_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'h47C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_clear,
  input  logic              do_feed,
  input  logic [FOLD_W-1:0] feed_byte,
  output logic [CRC_W-1:0]  crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= INIT;
    else if (do_clear) crc_q <= INIT;
    else if (do_feed)  crc_q <= crc_fold(crc_q, feed_byte, POLY);
  end
endmodule

// File: rtl/bus_crc16_count.sv
module bus_crc16_count #(
  parameter int CNT_W    = 12,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_clear,
  input  logic             do_feed,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_next;

  generate
    if (SATURATE) begin : g_sat
      always_comb cnt_next = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end else begin : g_wrap
      always_comb cnt_next = cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (do_clear) cnt_q <= '0;
    else if (do_feed)  cnt_q <= cnt_next;
  end
endmodule

// File: rtl/bus_crc16.sv
module bus_crc16
  import bus_crc16_pkg::*;
#(
  parameter int               DATA_W = 16,
  parameter int               CNT_W  = 12,
  parameter logic [CRC_W-1:0] POLY   = 16'h1021,
  parameter logic [CRC_W-1:0] INIT   = 16'h47C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int CLEAR_BIT = DATA_W - 1;

  logic              do_clear;
  logic              do_feed;
  logic [FOLD_W-1:0] feed_byte;
  logic [CRC_W-1:0]  crc_q;
  logic [CNT_W-1:0]  cnt_q;

  bus_crc16_decode #(.DATA_W(DATA_W), .CLEAR_BIT(CLEAR_BIT)) u_decode (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .do_clear(do_clear), .do_feed(do_feed), .feed_byte(feed_byte)
  );

  bus_crc16_accum #(.POLY(POLY), .INIT(INIT)) u_accum (
    .clk(clk), .rst_n(rst_n), .do_clear(do_clear), .do_feed(do_feed),
    .feed_byte(feed_byte), .crc_q(crc_q)
  );

  bus_crc16_count #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_count (
    .clk(clk), .rst_n(rst_n), .do_clear(do_clear), .do_feed(do_feed),
    .cnt_q(cnt_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (reg_sel_e'(bus_addr))
      SEL_CTRL: bus_rdata[CNT_W-1:0] = cnt_q;
      SEL_DOUT: bus_rdata[CRC_W-1:0] = crc_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bus_crc16_chk.sv
module bus_crc16_chk #(
  parameter int          DATA_W = 16,
  parameter int          CNT_W  = 12,
  parameter logic [15:0] INIT   = 16'h47C3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              do_clear,
  input logic              do_feed,
  input logic [15:0]       crc_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r2_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> (cnt_q == '0) && (crc_q == INIT));

  a_r3_no_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != 2'd1 && !(bus_addr == 2'd0 && bus_wdata[DATA_W-1]))
      |-> (!do_clear && !do_feed));

  a_r3_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_clear && !do_feed) |=> ($stable(cnt_q) && $stable(crc_q)));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (do_feed && !do_clear && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r6_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (do_feed && !do_clear && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  a_r8_ctrl_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

  a_r10_empty_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1 || bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

bind bus_crc16 bus_crc16_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .INIT(INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .do_clear(do_clear),
  .do_feed(do_feed), .crc_q(crc_q), .cnt_q(cnt_q)
);

// File: tb/bus_crc16_tb.sv
module bus_crc16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model_crc;
  int          model_cnt;

  always #5 clk = ~clk;

  bus_crc16 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Independent model: long division, one message bit at a time.
  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      fb = r[15] ^ b[k];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic feed(input logic [15:0] d);
    bus_write(2'd1, d);
    model_crc = ref_step(model_crc, d[7:0]);
    if (model_cnt < 4095) model_cnt++;
  endtask

  task automatic clear_model();
    model_crc = 16'h47C3;
    model_cnt = 0;
  endtask

  task automatic check_state(input string req);
    logic [15:0] v;
    bus_read(2'd0, v); check(req, v, 16'(model_cnt));
    bus_read(2'd2, v); check(req, v, model_crc);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bus_read(2'd0, v); check("R1 ctrl", v, 16'h0000);
    bus_read(2'd2, v); check("R1 result", v, 16'h47C3);
    clear_model();
  endtask

  task automatic t_selftest();
    logic [15:0] v;
    bus_write(2'd0, 16'h8000);
    bus_write(2'd1, 16'h00CC);
    bus_write(2'd1, 16'h00F5);
    bus_write(2'd1, 16'h00F1);
    bus_write(2'd1, 16'h00A7);
    bus_read(2'd0, v); check("R7 count", v, 16'h0004);
    bus_read(2'd2, v); check("R7 crc", v, 16'h51DF);
    clear_model();
    model_crc = ref_step(ref_step(ref_step(ref_step(model_crc, 8'hCC), 8'hF5), 8'hF1), 8'hA7);
    check("R4 model agrees with self-test", model_crc, 16'h51DF);
    model_cnt = 4;
  endtask

  task automatic t_next_cycle();
    logic [15:0] v;
    // write on one edge, read result at the following negedge
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h005A;
    @(negedge clk);
    bus_wr = 1'b0;
    model_crc = ref_step(model_crc, 8'h5A);
    model_cnt++;
    bus_read(2'd2, v); check("R9 crc next cycle", v, model_crc);
    bus_read(2'd0, v); check("R9 count next cycle", v, 16'(model_cnt));
  endtask

  task automatic t_noop_writes();
    bus_write(2'd0, 16'h7FFF);
    check_state("R3 ctrl without clear bit");
    bus_write(2'd2, 16'hFFFF);
    check_state("R3 write to result reg");
    bus_write(2'd3, 16'hFFFF);
    check_state("R3 write to unused reg");
  endtask

  task automatic t_reads();
    logic [15:0] v;
    bus_read(2'd1, v); check("R10 input reg read", v, 16'h0000);
    bus_read(2'd3, v); check("R10 unused read", v, 16'h0000);
  endtask

  task automatic t_clear_any_data();
    bus_write(2'd0, 16'hFFFF);
    clear_model();
    check_state("R2 clear with all bits set");
    bus_read(2'd0, bus_wdata);
    check("R8 clear bit reads 0", {bus_wdata[15:12], 12'h000}, 16'h0000);
  endtask

  task automatic t_high_bits_ignored();
    logic [15:0] v;
    feed(16'hF3C4);
    feed(16'h0A11);
    feed(16'h8F00);
    bus_read(2'd2, v); check("R4 high bits ignored", v, model_crc);
    bus_read(2'd0, v); check("R5 count after 3", v, 16'(model_cnt));
  endtask

  task automatic t_stream();
    logic [15:0] lf;
    logic [15:0] v;
    lf = 16'hACE1;
    bus_write(2'd0, 16'h8000);
    clear_model();
    for (int i = 0; i < 64; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      feed(lf);
      if (i % 16 == 15) begin
        bus_read(2'd2, v); check("R4 stream crc", v, model_crc);
        bus_read(2'd0, v); check("R5 stream count", v, 16'(model_cnt));
      end
    end
  endtask

  task automatic t_saturate();
    logic [15:0] v;
    bus_write(2'd0, 16'h8000);
    clear_model();
    for (int i = 0; i < 4094; i++) feed(16'(i));
    bus_read(2'd0, v); check("R5 count 4094", v, 16'd4094);
    feed(16'h0033);
    bus_read(2'd0, v); check("R6 count reaches max", v, 16'h0FFF);
    feed(16'h0044);
    feed(16'h0055);
    bus_read(2'd0, v); check("R6 count holds", v, 16'h0FFF);
    bus_read(2'd2, v); check("R4 crc past saturation", v, model_crc);
    bus_write(2'd0, 16'h8000);
    clear_model();
    check_state("R2 clear after saturation");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_selftest();
    t_next_cycle();
    t_noop_writes();
    t_reads();
    t_clear_any_data();
    t_high_bits_ignored();
    t_stream();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule